// File: doc/BRIEF.md
# Keyed Flow Signature Hash Engine

This block computes the two keyed hashes that a receive flow-steering stage needs for each flow: a bucket hash that picks a table row and a signature hash that tells flows in the same row apart. It takes a 352-bit flow tuple made of eleven 32-bit words and two 32-bit keys from configuration. Word 0 carries the flow type, pool and VLAN bits. Words 1 to 10 carry the addresses, ports and flexible bytes. The block returns both hashes packed into one 32-bit word, one registered cycle after the request.

The hash is an XOR fold, not a CRC. The ten address/port words are XORed into one common word. A high word is derived from it directly and a low word from its 16-bit rotation. The word-0 bits enter the high word before any key bit acts. They enter the low word only after key bit 0 has been applied. Each set key bit then XORs a shifted copy of the low or high word into a 15-bit result. The same tuple is hashed once with each key in parallel.

Top module: `flow_sig_hash`

## Requirements
- R1: A synchronous active-low reset clears `out_valid` and `out_hash` to zero at the next rising clock edge, whatever the inputs are.
- R2: `out_valid` is high in exactly those cycles that follow a cycle in which `in_valid` was high, and this holds for back-to-back requests.
- R3: `out_hash` changes only at the edge after a cycle with `in_valid` high. While `in_valid` is low it holds its value, even if the data inputs change.
- R4: Bits 15 and 31 of `out_hash` are always zero.
- R5: A key of all zeros gives a zero hash field, whatever the tuple is.
- R6: Each tuple word k sits at `in_tuple[32k+31:32k]` in network byte order. Bits [7:0] of that slice are the most significant byte of the word's value, and bits [31:24] are the least significant byte.
- R7: The common word C is the XOR of the values of words 1 to 10. Changing two of those words by the same XOR pattern leaves both hashes unchanged.
- R8: With only key bit 0 set, the hash is C[30:16]. Word 0 has no effect on it.
- R9: With only key bit 16 set, the hash is bits [14:0] of H = C ^ F ^ (F >> 16), where F is the value of word 0.
- R10: With only key bit i set, for i from 1 to 15, the hash is bits [14:0] of L >> i. Here L = {C[15:0], C[31:16]} ^ F ^ (F << 16).
- R11: With only key bit 16+i set, for i from 1 to 15, the hash is bits [14:0] of H >> i.
- R12: For a key with several bits set, the hash is the XOR of the single-bit results of its set bits.
- R13: `out_hash` places the hash computed with the signature key in bits 30:16 and the hash computed with the bucket key in bits 14:0. Both are computed from the same tuple, so equal keys give equal fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe; tuple and keys are taken in this cycle |
| in_tuple | input | 352 | Flow tuple, eleven big-endian 32-bit words, word k at bits 32k+31:32k |
| in_bkt_key | input | 32 | Key for the bucket hash |
| in_sig_key | input | 32 | Key for the signature hash |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_hash | output | 32 | Signature hash in 30:16, bucket hash in 14:0, bits 15 and 31 zero |

## Verification
The hardest case to reach from the ports is the asymmetric entry of word 0. It enters the low word after key bit 0 and the high word before key bit 16. A random key sets so many bits that an error in this ordering is hidden in the XOR of the other terms. The bench therefore sweeps every single-bit key on both lanes over a set of tuples. It compares each result with a closed-form value for that key bit. It also repeats the key-bit-0 case with only word 0 changed, to show that word 0 cannot reach that term. Random full keys against a per-bit loop model then cover how the terms combine.

// File: rtl/fsh_pkg.sv
// Shared constants and helpers for the flow signature hash engine.
// Assumes 32-bit tuple words built from four bytes.
package fsh_pkg;
    localparam int FSH_WORD_W = 32;
    localparam int FSH_HALF_W = FSH_WORD_W / 2;
    localparam int FSH_BYTES  = FSH_WORD_W / 8;

    // Reverse byte order: network-order slice to host value.
    function automatic logic [FSH_WORD_W-1:0] fsh_bswap(input logic [FSH_WORD_W-1:0] w);
        logic [FSH_WORD_W-1:0] r;
        for (int b = 0; b < FSH_BYTES; b++) begin
            r[8*b +: 8] = w[FSH_WORD_W-8-8*b +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/fsh_fold.sv
// Tuple fold stage. It converts every word to host order and XORs words 1..N-1
// into a common word. From that it derives the three key-independent operands:
//   lo_pre  : rotated common word, before word 0 is mixed in (key bit 0 only)
//   lo_post : rotated common word with F ^ (F << HALF) applied (key bits 1..HALF-1)
//   hi_word : common word with F ^ (F >> HALF) applied (key bits HALF..WORD_W-1)
// Only the bits the key mixer can select are carried out.
// Assumes HASH_W <= HALF so that every selected window stays inside the word.
module fsh_fold
    import fsh_pkg::*;
#(
    parameter int N_WORDS = 11,
    parameter int HASH_W  = 15
) (
    input  logic [N_WORDS*FSH_WORD_W-1:0] tuple,
    output logic [HASH_W-1:0]             lo_pre,
    output logic [HASH_W+FSH_HALF_W-2:1]  lo_post,
    output logic [HASH_W+FSH_HALF_W-2:0]  hi_word
);
    localparam int W     = FSH_WORD_W;
    localparam int HALF  = FSH_HALF_W;
    localparam int USE_W = HASH_W + HALF - 1;

    logic [W-1:0] host  [N_WORDS];
    logic [W-1:0] chain [N_WORDS];
    logic [W-1:0] common;
    logic [W-1:0] rot;
    logic [W-1:0] fv;

    // Per-word byte swap into host order.
    for (genvar g = 0; g < N_WORDS; g++) begin : g_host
        assign host[g] = fsh_bswap(tuple[g*W +: W]);
    end

    // XOR chain over words 1..N-1; word 0 is kept out of the fold.
    assign chain[0] = '0;
    for (genvar g = 1; g < N_WORDS; g++) begin : g_fold
        assign chain[g] = chain[g-1] ^ host[g];
    end

    assign common = chain[N_WORDS-1];
    assign rot    = {common[HALF-1:0], common[W-1:HALF]};
    assign fv     = host[0];

    // Derived operands, trimmed to the bit windows the mixer reads.
    assign lo_pre  = HASH_W'(rot);
    assign lo_post = (USE_W-1)'((rot ^ fv ^ (fv << HALF)) >> 1);
    assign hi_word = USE_W'(common ^ fv ^ (fv >> HALF));
endmodule

// File: rtl/fsh_keymix.sv
// Key mixer for one lane. Every set key bit selects a shifted window of the
// fold operands, and all selected windows are XORed into a HASH_W-bit hash.
// Bit 0 reads lo_pre, bits 1..HALF-1 read lo_post shifted by i, and bits
// HALF..WORD_W-1 read hi_word shifted by i-HALF.
// Assumes the operand widths produced by fsh_fold with the same HASH_W.
module fsh_keymix
    import fsh_pkg::*;
#(
    parameter int HASH_W = 15
) (
    input  logic [HASH_W-1:0]            lo_pre,
    input  logic [HASH_W+FSH_HALF_W-2:1] lo_post,
    input  logic [HASH_W+FSH_HALF_W-2:0] hi_word,
    input  logic [FSH_WORD_W-1:0]        key,
    output logic [HASH_W-1:0]            hash
);
    localparam int W    = FSH_WORD_W;
    localparam int HALF = FSH_HALF_W;

    logic [HASH_W-1:0] term [W];

    // One gated window per key bit.
    for (genvar i = 0; i < W; i++) begin : g_term
        if (i == 0) begin : g_b0
            assign term[i] = key[i] ? lo_pre : '0;
        end else if (i < HALF) begin : g_lo
            assign term[i] = key[i] ? lo_post[i +: HASH_W] : '0;
        end else begin : g_hi
            assign term[i] = key[i] ? hi_word[(i-HALF) +: HASH_W] : '0;
        end
    end

    // XOR reduction of all gated windows.
    always_comb begin
        hash = '0;
        for (int i = 0; i < W; i++) begin
            hash = hash ^ term[i];
        end
    end
endmodule

// File: rtl/flow_sig_hash.sv
// Top of the keyed flow signature hash engine. One shared fold stage feeds two
// key-mixer lanes (bucket key, signature key). The two hashes are packed into
// one word: signature in [HALF+HASH_W-1:HALF], bucket in [HASH_W-1:0], other
// bits zero. The result is registered, giving a latency of one cycle.
// Assumes HASH_W < HALF so that the padding bits exist.
module flow_sig_hash
    import fsh_pkg::*;
#(
    parameter int N_WORDS = 11,
    parameter int HASH_W  = 15
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [N_WORDS*FSH_WORD_W-1:0] in_tuple,
    input  logic [FSH_WORD_W-1:0]         in_bkt_key,
    input  logic [FSH_WORD_W-1:0]         in_sig_key,
    output logic                          out_valid,
    output logic [FSH_WORD_W-1:0]         out_hash
);
    localparam int W       = FSH_WORD_W;
    localparam int HALF    = FSH_HALF_W;
    localparam int USE_W   = HASH_W + HALF - 1;
    localparam int N_LANES = 2;

    logic [HASH_W-1:0] lo_pre;
    logic [USE_W-1:1]  lo_post;
    logic [USE_W-1:0]  hi_word;
    logic [W-1:0]      lane_key  [N_LANES];
    logic [HASH_W-1:0] lane_hash [N_LANES];
    logic [W-1:0]      packed_hash;

    fsh_fold #(
        .N_WORDS (N_WORDS),
        .HASH_W  (HASH_W)
    ) u_fold (
        .tuple   (in_tuple),
        .lo_pre  (lo_pre),
        .lo_post (lo_post),
        .hi_word (hi_word)
    );

    // Lane 0 uses the bucket key, lane 1 the signature key.
    assign lane_key[0] = in_bkt_key;
    assign lane_key[1] = in_sig_key;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        fsh_keymix #(
            .HASH_W (HASH_W)
        ) u_mix (
            .lo_pre  (lo_pre),
            .lo_post (lo_post),
            .hi_word (hi_word),
            .key     (lane_key[g]),
            .hash    (lane_hash[g])
        );
    end

    // Pack signature into the upper half and bucket into the lower half.
    always_comb begin
        packed_hash                       = '0;
        packed_hash[HASH_W-1:0]           = lane_hash[0];
        packed_hash[HALF+HASH_W-1:HALF]   = lane_hash[1];
    end

    // Output register: capture on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hash  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_hash <= packed_hash;
            end
        end
    end
endmodule

// File: rtl/fsh_checker.sv
// Protocol and packing properties of flow_sig_hash, bound to the top.
// It reads only the ports.
module fsh_checker
    import fsh_pkg::*;
#(
    parameter int HASH_W = 15
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [FSH_WORD_W-1:0] in_bkt_key,
    input logic [FSH_WORD_W-1:0] in_sig_key,
    input logic                  out_valid,
    input logic [FSH_WORD_W-1:0] out_hash
);
    localparam int HALF = FSH_HALF_W;

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_hash));

    assert_pad_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hash[HALF-1:HASH_W] == '0) && (out_hash[FSH_WORD_W-1:HALF+HASH_W] == '0));

    assert_zero_bkt_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bkt_key == '0) |=> (out_hash[HASH_W-1:0] == '0));

    assert_zero_sig_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sig_key == '0) |=> (out_hash[HALF+HASH_W-1:HALF] == '0));

    assert_equal_keys_equal_fields_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bkt_key == in_sig_key) |=>
        (out_hash[HALF+HASH_W-1:HALF] == out_hash[HASH_W-1:0]));
endmodule

bind flow_sig_hash fsh_checker #(.HASH_W(HASH_W)) u_fsh_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_bkt_key (in_bkt_key),
    .in_sig_key (in_sig_key),
    .out_valid  (out_valid),
    .out_hash   (out_hash)
);

// File: tb/tb_flow_sig_hash.sv
`timescale 1ns/1ps
// Self-checking bench for flow_sig_hash: single-bit key sweeps with closed-form
// expectations, random keys against a per-key-bit loop model, and handshake cases.
module tb_flow_sig_hash;
    localparam int NW = 11;
    localparam int TW = NW * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [TW-1:0] in_tuple = '0;
    logic [31:0]   in_bkt_key = '0;
    logic [31:0]   in_sig_key = '0;
    logic          out_valid;
    logic [31:0]   out_hash;

    int checks = 0;
    int errors = 0;

    flow_sig_hash dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_tuple   (in_tuple),
        .in_bkt_key (in_bkt_key),
        .in_sig_key (in_sig_key),
        .out_valid  (out_valid),
        .out_hash   (out_hash)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] wval(input logic [TW-1:0] t, input int k);
        logic [31:0] s;
        s = t[k*32 +: 32];
        return {s[7:0], s[15:8], s[23:16], s[31:24]};
    endfunction

    function automatic logic [31:0] cmn(input logic [TW-1:0] t);
        logic [31:0] c = '0;
        for (int k = 1; k < NW; k++) c = c ^ wval(t, k);
        return c;
    endfunction

    // Closed-form single-bit result from R8..R11.
    function automatic logic [14:0] one_bit(input logic [TW-1:0] t, input int i);
        logic [31:0] c, f, h, l;
        c = cmn(t);
        f = wval(t, 0);
        h = c ^ f ^ (f >> 16);
        l = {c[15:0], c[31:16]} ^ f ^ (f << 16);
        if (i == 0)       return c[30:16];
        else if (i < 16)  return 15'(l >> i);
        else              return 15'(h >> (i - 16));
    endfunction

    // Reference model: plain loop over the key bits.
    function automatic logic [14:0] ref_hash(input logic [TW-1:0] t, input logic [31:0] key);
        logic [31:0] c, f, hi, lo, acc;
        c  = cmn(t);
        f  = wval(t, 0);
        hi = c ^ f ^ (f >> 16);
        lo = {c[15:0], c[31:16]};
        acc = '0;
        if (key[0])  acc = acc ^ lo;
        if (key[16]) acc = acc ^ hi;
        lo = lo ^ f ^ (f << 16);
        for (int i = 1; i < 16; i++) begin
            if (key[i])      acc = acc ^ (lo >> i);
            if (key[i + 16]) acc = acc ^ (hi >> i);
        end
        return acc[14:0];
    endfunction

    function automatic logic [31:0] pack(input logic [14:0] s, input logic [14:0] b);
        return {1'b0, s, 1'b0, b};
    endfunction

    function automatic logic [TW-1:0] rnd_tuple();
        logic [TW-1:0] t;
        for (int k = 0; k < NW; k++) t[k*32 +: 32] = $urandom;
        return t;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One request; returns after the result is visible (sampled at negedge).
    task automatic apply(input logic [TW-1:0] t, input logic [31:0] bk, input logic [31:0] sk);
        @(negedge clk);
        in_tuple   = t;
        in_bkt_key = bk;
        in_sig_key = sk;
        in_valid   = 1'b1;
        @(negedge clk);
        in_valid   = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [TW-1:0] t, t2;
        logic [31:0]   r1, d;

        // R1: reset with busy inputs
        in_valid = 1'b1;
        in_tuple = rnd_tuple();
        in_bkt_key = 32'hFFFF_FFFF;
        in_sig_key = 32'h1234_5678;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", {31'b0, out_valid}, 32'h0);
        chk("R1 reset hash", out_hash, 32'h0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle after reset", {31'b0, out_valid}, 32'h0);

        // R6: byte order, only word 1 set to slice 0x00000100 -> value 0x00010000
        t = '0;
        t[32 +: 32] = 32'h0000_0100;
        apply(t, 32'h0000_0001, 32'h0001_0000);
        chk("R6 byte order", out_hash, pack(15'h0000, 15'h0001));
        chk("R2 valid after request", {31'b0, out_valid}, 32'h1);

        // R8..R11: every single-bit key on both lanes over several tuples
        for (int n = 0; n < 20; n++) begin
            if (n == 0)      t = '1;
            else if (n == 1) t = {NW{32'hA5C3_0F96}};
            else             t = rnd_tuple();
            for (int i = 0; i < 32; i++) begin
                int j = (i + 7) % 32;
                apply(t, 32'h1 << i, 32'h1 << j);
                if (i == 0)       chk("R8 key bit 0", out_hash, pack(one_bit(t, j), one_bit(t, i)));
                else if (i < 16)  chk("R10 low key bit", out_hash, pack(one_bit(t, j), one_bit(t, i)));
                else if (i == 16) chk("R9 key bit 16", out_hash, pack(one_bit(t, j), one_bit(t, i)));
                else              chk("R11 high key bit", out_hash, pack(one_bit(t, j), one_bit(t, i)));
            end
        end

        // R8: word 0 cannot reach the key-bit-0 term
        for (int n = 0; n < 8; n++) begin
            t = rnd_tuple();
            apply(t, 32'h1, 32'h1);
            r1 = out_hash;
            t[31:0] = ~t[31:0];
            apply(t, 32'h1, 32'h1);
            chk("R8 word0 ignored", out_hash, r1);
        end

        // R7: same XOR pattern on two fold words cancels
        for (int n = 0; n < 8; n++) begin
            t = rnd_tuple();
            d = $urandom;
            apply(t, $urandom, $urandom);
            r1 = out_hash;
            t2 = t;
            t2[3*32 +: 32] = t2[3*32 +: 32] ^ d;
            t2[8*32 +: 32] = t2[8*32 +: 32] ^ d;
            in_bkt_key = in_bkt_key;
            apply(t2, in_bkt_key, in_sig_key);
            chk("R7 fold cancel", out_hash, r1);
        end

        // R5: all-zero keys
        for (int n = 0; n < 6; n++) begin
            t = rnd_tuple();
            apply(t, 32'h0, 32'h0);
            chk("R5 zero keys", out_hash, 32'h0);
            apply(t, 32'h0, 32'hFFFF_FFFF);
            chk("R5 zero bucket key", out_hash, pack(ref_hash(t, 32'hFFFF_FFFF), 15'h0));
        end

        // R12, R13: random keys against the loop model
        for (int n = 0; n < 300; n++) begin
            logic [31:0] bk, sk;
            t  = rnd_tuple();
            bk = $urandom;
            sk = (n % 10 == 0) ? bk : $urandom;
            apply(t, bk, sk);
            chk("R12 R13 random keys", out_hash, pack(ref_hash(t, sk), ref_hash(t, bk)));
            chk("R4 pad bits", out_hash & 32'h8000_8000, 32'h0);
        end

        // R3: hold while idle with changing inputs
        t = rnd_tuple();
        apply(t, 32'hDEAD_BEEF, 32'h0BAD_F00D);
        r1 = out_hash;
        for (int n = 0; n < 4; n++) begin
            in_tuple = rnd_tuple();
            in_bkt_key = $urandom;
            in_sig_key = $urandom;
            @(negedge clk);
            chk("R3 hold hash", out_hash, r1);
            chk("R2 no valid when idle", {31'b0, out_valid}, 32'h0);
        end

        // R2: back-to-back burst, results one cycle behind requests
        begin
            logic [31:0] exp_q;
            for (int n = 0; n < 17; n++) begin
                @(negedge clk);
                if (n > 0) begin
                    chk("R2 burst valid", {31'b0, out_valid}, 32'h1);
                    chk("R2 burst hash", out_hash, exp_q);
                end
                if (n < 16) begin
                    t = rnd_tuple();
                    in_tuple = t;
                    in_bkt_key = $urandom;
                    in_sig_key = $urandom;
                    in_valid = 1'b1;
                    exp_q = pack(ref_hash(t, in_sig_key), ref_hash(t, in_bkt_key));
                end else begin
                    in_valid = 1'b0;
                end
            end
            @(negedge clk);
            chk("R2 burst end", {31'b0, out_valid}, 32'h0);
        end

        // R1: reset in mid-run clears a nonzero result
        apply('1, 32'hFFFF_FFFF, 32'h0000_FFFF);
        in_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset valid", {31'b0, out_valid}, 32'h0);
        chk("R1 mid-run reset hash", out_hash, 32'h0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule